// File: doc/BRIEF.md
# Serial Transmitter with Line Control

This block turns bytes into asynchronous serial frames on a single output line. Software programs an 8-bit line control register. That register sets the word length, the number of stop bits, the parity mode and a break override. A 16-bit baud divisor sets the bit rate. Bytes are then written to a one-deep holding register. The block moves each byte into a frame shifter, and the shifter sends a low start bit, the data bits least significant first, an optional parity bit and the stop bits.

Two register addresses are shared by two banks, chosen by the top bit of the line control register. With that bit clear, the addresses reach the holding register and an interrupt-enable byte. With it set, they reach the low and high divisor bytes. A status register reports when both the holding register and the shifter are empty. Software reads that bit before it touches the break control.

Top module: `utx_top`

## Requirements
- R1: After reset, the line control byte reads 0x00, both divisor bytes are 0, TXD is 1, and txEmpty is 1. The status register at address 5 reads with bit 6 (transmitter empty) and bit 5 (holding register empty) set.
- R2: With line control bit 7 set, address 0 reaches the low divisor byte and address 1 reaches the high divisor byte. With it clear, a write to address 0 loads the holding register, address 1 reads and writes the interrupt-enable byte, and a read of address 0 returns 0x00. A write in one bank leaves the other bank unchanged.
- R3: A frame begins with one low start bit, followed by the data bits least significant first. Line control bits 1:0 set the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the word length are not sent.
- R4: When line control bit 3 is 0, no parity bit is sent, and bits 4 and 5 have no effect on the frame.
- R5: When bit 3 is 1 and bit 5 is 0, a parity bit follows the data. With bit 4 = 1, the data bits and parity together hold an even number of ones. With bit 4 = 0, they hold an odd number.
- R6: When bits 3 and 5 are both 1, the parity bit is the inverse of bit 4, whatever the data.
- R7: Line control bit 2 = 0 gives one high stop bit. Bit 2 = 1 gives two stop bits, except with a 5-bit word, where it gives one and a half.
- R8: Each bit lasts 16 × divisor clock cycles, and a 1.5 stop bit lasts 24 × divisor cycles. While the divisor is 0, no frame starts and a pending byte stays pending.
- R9: Line control bit 6 forces TXD to 0 while it is set. The frame sequence and its timing, including when txEmpty rises, are the same as without the break.
- R10: txEmpty is 1 only when the holding register and the shifter are both empty. A byte written while a frame is in progress waits and is sent directly after that frame with no gap. A write in the same cycle that the shifter takes a byte is kept for the next frame.
- R11: The line control byte reads back at address 3. TXD is 1 whenever the transmitter is idle and no break is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register (combinational) |
| txd | output | 1 | Serial output |
| txEmpty | output | 1 | High when the holding register and the shifter are both empty |

## Verification
The holding-register write and the shifter's reload from that register can occur in the same clock edge. The bench forces this case by issuing a second data write on exactly the edge that starts the first frame. It then checks, at the middle of every bit, that the first byte and the second byte both go out in order and back to back. It also checks that txEmpty stays low until the last stop bit of the second frame has ended. Break and frame timing also overlap: with break set, the bench checks that TXD stays low at every bit position and that txEmpty rises on the same cycle it would without the break.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV_W = 2 * REG_W;
  localparam int FRAME_W = 12;
  localparam int BCNT_W = $clog2(FRAME_W + 1);

  localparam logic [ADDR_W-1:0] ADR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IEN = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LINE = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd5;

  typedef struct packed {
    logic brk;
    logic stky;
    logic evenSel;
    logic parEn;
    logic [1:0] wordSel;
  } lineCfg_t;

  typedef struct packed {
    logic load;
    logic shift;
  } utxStrobe_t;
endpackage

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output lineCfg_t          lineCfg,
  output logic [REG_W-1:0]  holdByte,
  output utxStrobe_t        strobe,
  output logic              busy,
  output logic              txEmpty,
  output logic [DIV_W-1:0]  divisor
);
  localparam int LONG_OVS = OVS + OVS / 2;
  localparam int SUB_W = $clog2(LONG_OVS);

  logic [REG_W-1:0] lineQ, ienQ, divLoQ, divHiQ, holdQ;
  logic holdFull;
  logic [DIV_W-1:0] divCnt;
  logic [SUB_W-1:0] subCnt, bitLimit;
  logic [BCNT_W-1:0] bitsLeft, frameLen;
  logic longLast;
  logic bankSel, divNz, subTick, lastBit, bitDone, frameEnd, loadNow;
  logic wrHold, wrIen, wrDivLo, wrDivHi, wrLine;

  assign bankSel = lineQ[7];
  assign divisor = {divHiQ, divLoQ};
  assign divNz = divisor != '0;
  assign holdByte = holdQ;

  assign wrHold  = regWr && regAddr == ADR_DATA && !bankSel;
  assign wrDivLo = regWr && regAddr == ADR_DATA && bankSel;
  assign wrIen   = regWr && regAddr == ADR_IEN && !bankSel;
  assign wrDivHi = regWr && regAddr == ADR_IEN && bankSel;
  assign wrLine  = regWr && regAddr == ADR_LINE;

  assign lineCfg = '{brk: lineQ[6], stky: lineQ[5], evenSel: lineQ[4],
                     parEn: lineQ[3], wordSel: lineQ[1:0]};

  // start + data (5..8) + parity + stop bits (2 only when 2 stops apply)
  always_comb begin
    frameLen = BCNT_W'(6) + BCNT_W'(lineQ[1:0]) + BCNT_W'(lineQ[3]);
    if (lineQ[2] && lineQ[1:0] != 2'b00) frameLen = frameLen + BCNT_W'(2);
    else frameLen = frameLen + BCNT_W'(1);
  end

  assign subTick = busy && divNz &&
                   (({1'b0, divCnt} + (DIV_W+1)'(1)) >= {1'b0, divisor});
  assign lastBit = bitsLeft == BCNT_W'(1);
  assign bitLimit = (lastBit && longLast) ? SUB_W'(LONG_OVS - 1) : SUB_W'(OVS - 1);
  assign bitDone = subTick && subCnt == bitLimit;
  assign frameEnd = bitDone && lastBit;
  assign loadNow = holdFull && divNz && (!busy || frameEnd);

  assign strobe = '{load: loadNow, shift: bitDone && !lastBit};
  assign txEmpty = !busy && !holdFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ <= '0;
      ienQ <= '0;
      divLoQ <= '0;
      divHiQ <= '0;
      holdQ <= '0;
      holdFull <= 1'b0;
    end else begin
      if (wrLine) lineQ <= regWrData;
      if (wrIen) ienQ <= regWrData;
      if (wrDivLo) divLoQ <= regWrData;
      if (wrDivHi) divHiQ <= regWrData;
      if (wrHold) holdQ <= regWrData;
      if (wrHold) holdFull <= 1'b1;
      else if (loadNow) holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      divCnt <= '0;
      subCnt <= '0;
      bitsLeft <= '0;
      longLast <= 1'b0;
    end else if (loadNow) begin
      busy <= 1'b1;
      divCnt <= '0;
      subCnt <= '0;
      bitsLeft <= frameLen;
      longLast <= lineQ[2] && lineQ[1:0] == 2'b00;
    end else if (frameEnd) begin
      busy <= 1'b0;
      divCnt <= '0;
      subCnt <= '0;
      bitsLeft <= '0;
    end else if (busy && divNz) begin
      divCnt <= subTick ? '0 : divCnt + DIV_W'(1);
      if (subTick) begin
        subCnt <= bitDone ? '0 : subCnt + SUB_W'(1);
        if (bitDone) bitsLeft <= bitsLeft - BCNT_W'(1);
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADR_DATA: regRdData = bankSel ? divLoQ : '0;
      ADR_IEN:  regRdData = bankSel ? divHiQ : ienQ;
      ADR_LINE: regRdData = lineQ;
      ADR_STAT: regRdData = {1'b0, txEmpty, !holdFull, 5'b0};
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/utx_dp.sv
module utx_dp
  import utx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  utxStrobe_t       strobe,
  input  lineCfg_t         lineCfg,
  input  logic [REG_W-1:0] holdByte,
  input  logic             busy,
  output logic             txd
);
  logic [FRAME_W-1:0] shiftQ, frameNext;
  logic [REG_W-1:0] dataMask;
  logic parBit;
  int unsigned dataLen;

  always_comb begin
    dataLen = 5 + int'(lineCfg.wordSel);
    for (int i = 0; i < REG_W; i++) dataMask[i] = (i < dataLen) ? holdByte[i] : 1'b0;
    if (lineCfg.stky) parBit = !lineCfg.evenSel;
    else parBit = lineCfg.evenSel ? ^dataMask : ~^dataMask;
  end

  generate
    for (genvar k = 0; k < FRAME_W; k++) begin : g_frame
      if (k == 0) begin : g_start
        assign frameNext[k] = 1'b0;
      end else if (k <= REG_W) begin : g_data
        assign frameNext[k] = (k <= dataLen) ? dataMask[k-1] :
                              (k == dataLen + 1 && lineCfg.parEn) ? parBit : 1'b1;
      end else begin : g_tail
        assign frameNext[k] = (k == dataLen + 1 && lineCfg.parEn) ? parBit : 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '1;
    else if (strobe.load) shiftQ <= frameNext;
    else if (strobe.shift) shiftQ <= {1'b1, shiftQ[FRAME_W-1:1]};
  end

  assign txd = lineCfg.brk ? 1'b0 : (busy ? shiftQ[0] : 1'b1);
endmodule

// File: rtl/utx_top.sv
module utx_top
  import utx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              txd,
  output logic              txEmpty
);
  lineCfg_t lineCfg;
  utxStrobe_t strobe;
  logic [REG_W-1:0] holdByte;
  logic busy;
  logic [DIV_W-1:0] divisor;

  utx_ctrl #(.OVS(OVS)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .lineCfg(lineCfg),
    .holdByte(holdByte), .strobe(strobe), .busy(busy), .txEmpty(txEmpty),
    .divisor(divisor)
  );

  utx_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineCfg(lineCfg),
    .holdByte(holdByte), .busy(busy), .txd(txd)
  );
endmodule

// File: rtl/utx_chk.sv
module utx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        txd,
  input logic        txEmpty,
  input logic        brk,
  input logic        busy,
  input logic [15:0] divisor
);
  // R9
  brk_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    brk |-> !txd);

  // R11
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !brk) |-> txd);

  // R3
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !brk) |-> !txd);

  // R8
  zero_div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == 16'd0) |=> $stable(busy));

  // R10
  busy_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !txEmpty);
endmodule

bind utx_top utx_chk i_chk (
  .clk(clk), .rstN(rstN), .txd(txd), .txEmpty(txEmpty),
  .brk(lineCfg.brk), .busy(busy), .divisor(divisor)
);

// File: tb/test_utx_top.sv
`timescale 1ns/1ps
module test_utx_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic txd, txEmpty;

  int nChecks = 0;
  int nFail = 0;
  bit expTx [0:1023];
  bit expMid [0:1023];
  int tot = 0;

  always #2 clk = ~clk;

  utx_top i_utx_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .txd(txd), .txEmpty(txEmpty)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setDiv(input int div, input logic [7:0] line);
    wrReg(3'd3, 8'h80 | line);
    wrReg(3'd0, 8'(div));
    wrReg(3'd1, 8'(div >> 8));
    wrReg(3'd3, line);
  endtask

  task automatic addBit(input bit v, input int len);
    for (int j = 0; j < len; j++) begin
      expTx[tot + j] = v;
      expMid[tot + j] = (j == len / 2);
    end
    tot += len;
  endtask

  task automatic addFrame(input logic [7:0] d, input logic [7:0] line, input int div);
    int nData = 5 + int'(line[1:0]);
    int ones = 0;
    bit par;
    addBit(1'b0, 16 * div);
    for (int i = 0; i < nData; i++) begin
      addBit(d[i], 16 * div);
      ones += int'(d[i]);
    end
    if (line[3]) begin
      if (line[5]) par = !line[4];
      else if (line[4]) par = (ones % 2) == 1;
      else par = (ones % 2) == 0;
      addBit(par, 16 * div);
    end
    if (line[2] && line[1:0] == 2'b00) addBit(1'b1, 24 * div);
    else if (line[2]) begin addBit(1'b1, 16 * div); addBit(1'b1, 16 * div); end
    else addBit(1'b1, 16 * div);
  endtask

  // writes d0 (and d1 on the very edge that loads d0), then walks the expected waveform
  task automatic runFrames(input logic [7:0] d0, input bit two, input logic [7:0] d1,
                           input bit brk, input string req);
    @(negedge clk);
    regAddr = 3'd0; regWrData = d0; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    if (two) begin regWrData = d1; regWr = 1'b1; end
    for (int c = 0; c <= tot; c++) begin
      @(negedge clk);
      regWr = 1'b0;
      if (c < tot && expMid[c]) chk(req, int'(txd), brk ? 0 : int'(expTx[c]));
      if (c == tot - 1) chk({req, " R10 busy"}, int'(txEmpty), 0);
      if (c == tot) chk({req, " R10 done"}, int'(txEmpty), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] line;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 txd", int'(txd), 1);
    chk("R1 txEmpty", int'(txEmpty), 1);
    rdReg(3'd3, rd); chk("R1 line", int'(rd), 0);
    rdReg(3'd5, rd); chk("R1 status", int'(rd), 8'h60);
    wrReg(3'd3, 8'h80);
    rdReg(3'd0, rd); chk("R1 divLo", int'(rd), 0);
    rdReg(3'd1, rd); chk("R1 divHi", int'(rd), 0);

    // R2 banking
    wrReg(3'd0, 8'h34);
    wrReg(3'd1, 8'h12);
    chk("R2 divLo write kept off holding", int'(txEmpty), 1);
    rdReg(3'd0, rd); chk("R2 divLo", int'(rd), 8'h34);
    rdReg(3'd1, rd); chk("R2 divHi", int'(rd), 8'h12);
    wrReg(3'd3, 8'h03);
    rdReg(3'd3, rd); chk("R11 line readback", int'(rd), 8'h03);
    rdReg(3'd1, rd); chk("R2 ien reset", int'(rd), 0);
    wrReg(3'd1, 8'h0A);
    rdReg(3'd1, rd); chk("R2 ien", int'(rd), 8'h0A);
    rdReg(3'd0, rd); chk("R2 data read", int'(rd), 0);
    wrReg(3'd3, 8'h83);
    rdReg(3'd1, rd); chk("R2 divHi untouched", int'(rd), 8'h12);
    rdReg(3'd0, rd); chk("R2 divLo untouched", int'(rd), 8'h34);
    wrReg(3'd0, 8'h00);
    wrReg(3'd1, 8'h00);
    wrReg(3'd3, 8'h03);
    rdReg(3'd1, rd); chk("R2 ien untouched", int'(rd), 8'h0A);

    // R8 divisor zero holds the byte pending
    wrReg(3'd0, 8'hA5);
    repeat (100) @(negedge clk);
    chk("R8 div0 txd", int'(txd), 1);
    chk("R8 div0 pending", int'(txEmpty), 0);
    rdReg(3'd5, rd); chk("R8 div0 status", int'(rd), 8'h00);
    setDiv(1, 8'h03);
    for (int w = 0; w < 400 && !txEmpty; w++) @(negedge clk);
    chk("R8 frame after divisor set", int'(txEmpty), 1);

    // R3-R7 sweep over every framing/parity combination
    for (int cfg = 0; cfg < 64; cfg++) begin
      line = 8'(cfg);
      wrReg(3'd3, line);
      for (int v = 0; v < 2; v++) begin
        d = 8'(cfg * 37 + 11);
        if (v == 1) d = ~d;
        tot = 0;
        addFrame(d, line, 1);
        runFrames(d, 1'b0, 8'h00, 1'b0, "R3 R4 R5 R6 R7 frame");
      end
    end

    // R8 divisor 2, R7 1.5 stop at that rate
    setDiv(2, 8'h1B);
    tot = 0; addFrame(8'hC3, 8'h1B, 2);
    runFrames(8'hC3, 1'b0, 8'h00, 1'b0, "R8 div2");
    wrReg(3'd3, 8'h04);
    tot = 0; addFrame(8'h16, 8'h04, 2);
    runFrames(8'h16, 1'b0, 8'h00, 1'b0, "R7 R8 1.5 stop div2");
    setDiv(1, 8'h03);

    // R10 coincident write on the load edge, back to back frames
    tot = 0; addFrame(8'h5A, 8'h03, 1); addFrame(8'h81, 8'h03, 1);
    runFrames(8'h5A, 1'b1, 8'h81, 1'b0, "R10 back to back");
    wrReg(3'd3, 8'h2C);
    tot = 0; addFrame(8'h0F, 8'h2C, 1); addFrame(8'h13, 8'h2C, 1);
    runFrames(8'h0F, 1'b1, 8'h13, 1'b0, "R10 back to back parity");

    // R9 break
    wrReg(3'd3, 8'h4B);
    chk("R9 idle break", int'(txd), 0);
    tot = 0; addFrame(8'hFF, 8'h4B, 1);
    runFrames(8'hFF, 1'b0, 8'h00, 1'b1, "R9 break frame");
    wrReg(3'd3, 8'h0B);
    chk("R11 break cleared", int'(txd), 1);
    tot = 0; addFrame(8'hFF, 8'h0B, 1);
    runFrames(8'hFF, 1'b0, 8'h00, 1'b0, "R9 after break");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule